// File: doc/BRIEF.md
# Real-time MIDI byte extractor

This block gathers real-time MIDI bytes from two sources and delivers them as one stream of valid/byte pulses to a downstream MIDI parser. The first source is a serial receive line that carries standard MIDI framing at 31250 bit/s. The second source is a byte-wide data port. On the data port, every MIDI byte comes in a pair with one zero pad byte. The pad byte sits either after the payload byte or before it, and one order applies at a time. The block removes the pads and passes the payload bytes on in arrival order.

A mode input controls whether the data port is accepted. When it is low, only the serial line is accepted. A second input selects the pad order. A pad slot that holds a nonzero byte raises a sticky error. When the serial receiver and the data port finish a byte in the same cycle, the serial byte is delivered first. The data-port byte is held for one cycle and delivered next.

Top module: `rtmidi_extract`

## Requirements
- R1: After synchronous reset, `out_valid` and `pad_err` are 0, and the next data-port byte is taken as the first slot of a pair.
- R2: The serial line is received as 8N1 frames: one low start bit, eight data bits least significant bit first, and one high stop bit. Each bit lasts 16 oversample ticks of `OVS_DIV` clocks. Each received byte is delivered exactly once on `out_byte`.
- R3: A falling edge on the serial line that is no longer low half a bit later is rejected. It produces no output.
- R4: A frame whose stop bit is sampled low is discarded. The receiver then accepts the next good frame.
- R5: With `pad_first`=0, each pair is the payload followed by 0x00. With `pad_first`=1, each pair is 0x00 followed by the payload. Payload bytes of any value, 0x00 included, are delivered in order and the pads are removed. For example, 0x92 0x00 0x37 0x00 0x73 0x00 yields 0x92 0x37 0x73.
- R6: A nonzero byte in a pad slot is delivered as a payload byte and sets `pad_err`. `pad_err` stays set until reset. The byte after it is still taken as a pad slot.
- R7: While `mode_both`=0, data-port bytes produce no output and no error, and the pair phase returns to the first slot. Serial bytes are still delivered.
- R8: When a serial byte and a data-port payload byte complete in the same cycle, the serial byte appears on `out_valid` first. The data-port byte appears in the following cycle.
- R9: The outputs are registered. A data-port payload byte presented at clock edge k appears at edge k+2 as a single-cycle `out_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uart_rx | input | 1 | Asynchronous serial receive line, idle high |
| dp_valid | input | 1 | Data-port byte strobe |
| dp_byte | input | 8 | Data-port byte |
| mode_both | input | 1 | 1: serial line and data port both accepted; 0: serial line only |
| pad_first | input | 1 | 0: pad follows payload; 1: pad precedes payload |
| out_valid | output | 1 | One-cycle strobe for a recovered MIDI byte |
| out_byte | output | 8 | Recovered MIDI byte |
| pad_err | output | 1 | Sticky flag: a nonzero byte was seen in a pad slot |

## Verification
The serial path is driven with all 256 byte values. This shows that bit order and byte assembly are correct across every value. Short low glitches and frames with a low stop bit are also sent, which separates a valid start from a false one and a valid frame from a framing error. The data port is swept with all 256 payload values in both pad orders, including the zero payload, which only a correct pair phase can tell apart from a pad. Further sequences cover a nonzero pad, phase recovery after the mode is switched off, and a serial byte and a data-port byte timed to complete in the same cycle, which checks the delivery order.

// File: rtl/rtm_pkg.sv
package rtm_pkg;
  localparam int OVS = 16;
  localparam int BYTE_W = 8;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
endpackage

// File: rtl/rtm_uart_rx.sv
module rtm_uart_rx import rtm_pkg::*; #(
  parameter int OVS_DIV = 500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx,
  output logic              byte_v,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int DW = $clog2(OVS_DIV + 1);
  localparam int TW = $clog2(OVS);
  localparam int BW = $clog2(BYTE_W);

  logic          rx_s1, rx_s2;
  logic [DW-1:0] div_cnt;
  logic          tick;
  rx_state_t     st;
  logic [TW-1:0] tcnt;
  logic [BW-1:0] bcnt;
  logic [BYTE_W-1:0] shreg;

  assign tick = (div_cnt == DW'(OVS_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_s1 <= 1'b1;
      rx_s2 <= 1'b1;
      div_cnt <= '0;
    end else begin
      rx_s1 <= rx;
      rx_s2 <= rx_s1;
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= RX_IDLE;
      tcnt <= '0;
      bcnt <= '0;
      shreg <= '0;
      byte_v <= 1'b0;
      byte_o <= '0;
    end else begin
      byte_v <= 1'b0;
      if (tick) begin
        case (st)
          RX_IDLE: begin
            if (!rx_s2) begin
              st <= RX_START;
              tcnt <= '0;
            end
          end
          RX_START: begin
            if (tcnt == TW'(OVS/2 - 1)) begin
              tcnt <= '0;
              bcnt <= '0;
              st <= rx_s2 ? RX_IDLE : RX_DATA;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (tcnt == TW'(OVS - 1)) begin
              tcnt <= '0;
              shreg <= {rx_s2, shreg[BYTE_W-1:1]};
              if (bcnt == BW'(BYTE_W - 1)) st <= RX_STOP;
              else bcnt <= bcnt + 1'b1;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          default: begin
            if (tcnt == TW'(OVS - 1)) begin
              tcnt <= '0;
              st <= RX_IDLE;
              if (rx_s2) begin
                byte_v <= 1'b1;
                byte_o <= shreg;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/rtm_pad_strip.sv
module rtm_pad_strip import rtm_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              pad_first,
  input  logic              dp_valid,
  input  logic [BYTE_W-1:0] dp_byte,
  output logic              pl_valid,
  output logic [BYTE_W-1:0] pl_byte,
  output logic              err
);
  logic phase;
  logic slot_is_pad;

  assign slot_is_pad = phase ^ pad_first;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 1'b0;
      pl_valid <= 1'b0;
      pl_byte <= '0;
      err <= 1'b0;
    end else begin
      pl_valid <= 1'b0;
      if (!en) begin
        phase <= 1'b0;
      end else if (dp_valid) begin
        if (!slot_is_pad) begin
          pl_valid <= 1'b1;
          pl_byte <= dp_byte;
          phase <= ~phase;
        end else if (dp_byte == '0) begin
          phase <= ~phase;
        end else begin
          pl_valid <= 1'b1;
          pl_byte <= dp_byte;
          err <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rtm_merge.sv
module rtm_merge import rtm_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              u_v,
  input  logic [BYTE_W-1:0] u_b,
  input  logic              d_v,
  input  logic [BYTE_W-1:0] d_b,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic              buf_full
);
  logic [BYTE_W-1:0] buf_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_byte <= '0;
      buf_full <= 1'b0;
      buf_b <= '0;
    end else begin
      out_valid <= u_v | buf_full | d_v;
      if (u_v) begin
        out_byte <= u_b;
        if (d_v) begin
          buf_full <= 1'b1;
          buf_b <= d_b;
        end
      end else if (buf_full) begin
        out_byte <= buf_b;
        buf_full <= d_v;
        if (d_v) buf_b <= d_b;
      end else if (d_v) begin
        out_byte <= d_b;
      end
    end
  end
endmodule

// File: rtl/rtmidi_extract.sv
module rtmidi_extract import rtm_pkg::*; #(
  parameter int OVS_DIV = 500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       uart_rx,
  input  logic       dp_valid,
  input  logic [7:0] dp_byte,
  input  logic       mode_both,
  input  logic       pad_first,
  output logic       out_valid,
  output logic [7:0] out_byte,
  output logic       pad_err
);
  logic              u_v, d_v, buf_full;
  logic [BYTE_W-1:0] u_b, d_b;

  rtm_uart_rx #(.OVS_DIV(OVS_DIV)) u_rx (
    .clk(clk), .rst(rst), .rx(uart_rx), .byte_v(u_v), .byte_o(u_b)
  );

  rtm_pad_strip u_strip (
    .clk(clk), .rst(rst), .en(mode_both), .pad_first(pad_first),
    .dp_valid(dp_valid), .dp_byte(dp_byte),
    .pl_valid(d_v), .pl_byte(d_b), .err(pad_err)
  );

  rtm_merge u_mrg (
    .clk(clk), .rst(rst), .u_v(u_v), .u_b(u_b), .d_v(d_v), .d_b(d_b),
    .out_valid(out_valid), .out_byte(out_byte), .buf_full(buf_full)
  );
endmodule

// File: rtl/rtmidi_extract_chk.sv
module rtmidi_extract_chk (
  input logic clk,
  input logic rst,
  input logic dp_valid,
  input logic mode_both,
  input logic u_v,
  input logic d_v,
  input logic buf_full,
  input logic out_valid,
  input logic pad_err
);
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    pad_err |=> pad_err);

  p_err_source_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(pad_err) |-> $past(dp_valid && mode_both));

  p_ignore_r7: assert property (@(posedge clk) disable iff (rst)
    !mode_both |=> !d_v);

  p_tie_order_r8: assert property (@(posedge clk) disable iff (rst)
    (u_v && d_v) |=> (out_valid && buf_full));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    !(u_v && d_v && buf_full));

  p_pulse_source_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(u_v || d_v || buf_full));
endmodule

bind rtmidi_extract rtmidi_extract_chk u_chk (
  .clk(clk), .rst(rst), .dp_valid(dp_valid), .mode_both(mode_both),
  .u_v(u_v), .d_v(d_v), .buf_full(buf_full),
  .out_valid(out_valid), .pad_err(pad_err)
);

// File: tb/rtmidi_extract_test.sv
`timescale 1ns/1ps
module rtmidi_extract_test;
  localparam int DIV = 2;
  localparam int BIT = 16 * DIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic uart_rx = 1'b1;
  logic dp_valid = 1'b0;
  logic [7:0] dp_byte = '0;
  logic mode_both = 1'b1;
  logic pad_first = 1'b0;
  logic out_valid;
  logic [7:0] out_byte;
  logic pad_err;

  int total = 0;
  int bad = 0;
  int cyc;
  int ng;
  logic [7:0] got [0:1023];
  int got_cyc [0:1023];

  always #2 clk = ~clk;

  rtmidi_extract #(.OVS_DIV(DIV)) uut (
    .clk(clk), .rst(rst), .uart_rx(uart_rx), .dp_valid(dp_valid),
    .dp_byte(dp_byte), .mode_both(mode_both), .pad_first(pad_first),
    .out_valid(out_valid), .out_byte(out_byte), .pad_err(pad_err)
  );

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (!rst && out_valid && ng < 1024) begin
      got[ng] = out_byte;
      got_cyc[ng] = cyc;
      ng = ng + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    dp_valid = 1'b0;
    uart_rx = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    ng = 0;
  endtask

  task automatic dp_put(input logic [7:0] b);
    @(negedge clk);
    dp_valid = 1'b1;
    dp_byte = b;
    @(negedge clk);
    dp_valid = 1'b0;
  endtask

  task automatic uart_send(input logic [7:0] b, input bit good_stop);
    uart_rx = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      uart_rx = b[i];
      repeat (BIT) @(negedge clk);
    end
    if (good_stop) begin
      uart_rx = 1'b1;
      repeat (BIT) @(negedge clk);
    end else begin
      uart_rx = 1'b0;
      repeat (10 * DIV) @(negedge clk);
      uart_rx = 1'b1;
      repeat (2 * BIT) @(negedge clk);
    end
    repeat (BIT) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int e;
    ng = 0;
    do_reset();
    @(negedge clk);
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(pad_err == 0, "R1 pad_err", pad_err, 0);

    // R2: all serial byte values
    for (int v = 0; v < 256; v++) uart_send(8'(v), 1'b1);
    chk(ng == 256, "R2 count", ng, 256);
    for (int v = 0; v < 256; v++) if (got[v] != 8'(v)) chk(0, "R2 byte", got[v], v);
    chk(1, "R2 bytes", 0, 0);

    // R9: latency and single pulse
    do_reset();
    @(negedge clk);
    dp_valid = 1'b1; dp_byte = 8'h92;
    @(negedge clk);
    dp_valid = 1'b0;
    chk(out_valid == 0, "R9 early", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1 && out_byte == 8'h92, "R9 latency", out_byte, 8'h92);
    @(negedge clk);
    chk(out_valid == 0, "R9 single pulse", out_valid, 0);
    dp_put(8'h00);

    // R5: example message, pad after
    ng = 0;
    dp_put(8'h92); dp_put(8'h00); dp_put(8'h37); dp_put(8'h00); dp_put(8'h73); dp_put(8'h00);
    repeat (4) @(negedge clk);
    chk(ng == 3 && got[0] == 8'h92 && got[1] == 8'h37 && got[2] == 8'h73,
        "R5 example", {got[0], got[1], got[2]}, 24'h923773);

    // R5: sweep, pad after
    ng = 0;
    for (int v = 0; v < 256; v++) begin dp_put(8'(v)); dp_put(8'h00); end
    repeat (4) @(negedge clk);
    chk(ng == 256, "R5 pad-after count", ng, 256);
    for (int v = 0; v < 256; v++) if (got[v] != 8'(v)) chk(0, "R5 pad-after byte", got[v], v);
    chk(pad_err == 0, "R5 pad-after no error", pad_err, 0);

    // R5: sweep, pad before
    do_reset();
    pad_first = 1'b1;
    for (int v = 0; v < 256; v++) begin dp_put(8'h00); dp_put(8'(v)); end
    repeat (4) @(negedge clk);
    chk(ng == 256, "R5 pad-before count", ng, 256);
    for (int v = 0; v < 256; v++) if (got[v] != 8'(v)) chk(0, "R5 pad-before byte", got[v], v);
    chk(pad_err == 0, "R5 pad-before no error", pad_err, 0);

    // R6: nonzero pad
    do_reset();
    pad_first = 1'b0;
    dp_put(8'h90); dp_put(8'h45); dp_put(8'h00); dp_put(8'h12); dp_put(8'h00);
    repeat (4) @(negedge clk);
    chk(ng == 3, "R6 count", ng, 3);
    chk(got[0] == 8'h90 && got[1] == 8'h45 && got[2] == 8'h12, "R6 bytes",
        {got[0], got[1], got[2]}, 24'h904512);
    chk(pad_err == 1, "R6 error set", pad_err, 1);
    dp_put(8'h21); dp_put(8'h00);
    repeat (4) @(negedge clk);
    chk(pad_err == 1, "R6 error sticky", pad_err, 1);
    do_reset();
    @(negedge clk);
    chk(pad_err == 0, "R1 error cleared by reset", pad_err, 0);

    // R7: data port ignored when mode_both is low
    dp_put(8'h33);
    repeat (4) @(negedge clk);
    ng = 0;
    mode_both = 1'b0;
    dp_put(8'h55); dp_put(8'h66); dp_put(8'h77);
    repeat (4) @(negedge clk);
    chk(ng == 0, "R7 no output", ng, 0);
    chk(pad_err == 0, "R7 no error", pad_err, 0);
    uart_send(8'hFA, 1'b1);
    chk(ng == 1 && got[0] == 8'hFA, "R7 serial kept", got[0], 8'hFA);
    mode_both = 1'b1;
    ng = 0;
    dp_put(8'h44); dp_put(8'h00);
    repeat (4) @(negedge clk);
    chk(ng == 1 && got[0] == 8'h44 && pad_err == 0, "R7 phase restart", got[0], 8'h44);

    // R3: short glitch
    ng = 0;
    uart_rx = 1'b0;
    repeat (3 * DIV) @(negedge clk);
    uart_rx = 1'b1;
    repeat (3 * BIT) @(negedge clk);
    chk(ng == 0, "R3 glitch rejected", ng, 0);

    // R4: low stop bit, then a good frame
    uart_send(8'hC3, 1'b0);
    chk(ng == 0, "R4 bad stop dropped", ng, 0);
    uart_send(8'hFE, 1'b1);
    chk(ng == 1 && got[0] == 8'hFE, "R4 recovers", got[0], 8'hFE);

    // R8: same-cycle completion
    do_reset();
    while (cyc != 10) @(negedge clk);
    uart_send(8'hF8, 1'b1);
    e = got_cyc[0];
    chk(ng == 1 && got[0] == 8'hF8, "R8 reference run", got[0], 8'hF8);
    do_reset();
    fork
      begin
        while (cyc != 10) @(negedge clk);
        uart_send(8'hF8, 1'b1);
      end
      begin
        while (cyc != e - 2) @(negedge clk);
        dp_valid = 1'b1; dp_byte = 8'h5A;
        @(negedge clk);
        dp_valid = 1'b0;
      end
    join
    chk(ng == 2, "R8 count", ng, 2);
    chk(got[0] == 8'hF8 && got_cyc[0] == e, "R8 serial first", got[0], 8'hF8);
    chk(got[1] == 8'h5A && got_cyc[1] == e + 1, "R8 data next cycle", got[1], 8'h5A);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule